// File: doc/BRIEF.md
# Lane-Parallel Saturating Vector Arithmetic Unit

This unit performs clamped integer arithmetic on packed vectors. One operand vector (or two, for the binary operations) is split into lanes of 8, 16, 32 or 64 bits. Each lane is computed on its own, and a result that would leave the lane's representable range is pinned to the nearest bound. Four operations are provided: add and subtract (signed or unsigned), and absolute value and negation (always signed). The unit works on a 128-bit or 64-bit vector, or on one scalar element held in the lowest lane.

A request is presented with a one-cycle strobe. The clamped vector and the updated status word appear together one cycle later, marked by an output valid. Lanes outside the active width are written as zero. Any clamp in an active lane sets a sticky flag at bit 27 of the status word. The arithmetic never clears this flag; only the explicit clear input does.

Top module: `sat_vec_alu`

## Requirements
- R1: `size_sel` selects the lane width as 8 << size_sel (0 = 8 bits, 1 = 16, 2 = 32, 3 = 64). Lane k occupies bits [k*W +: W], where W is the lane width. The lane count is the active byte count divided by W/8.
- R2: Signed add (`op_sel` = 0, `signed_mode` = 1) returns the exact sum when it fits the lane. It returns the most negative value on overflow when `src_a` is negative, and the most positive value on overflow otherwise.
- R3: Signed subtract (`op_sel` = 1, `signed_mode` = 1) returns `src_a` - `src_b` and clamps exactly as in R2.
- R4: Unsigned add (`op_sel` = 0, `signed_mode` = 0) returns all ones on carry out. Unsigned subtract (`op_sel` = 1, `signed_mode` = 0) returns zero when `src_a` < `src_b`. In every other case both return the exact lane result.
- R5: Absolute value (`op_sel` = 2) and negation (`op_sel` = 3) act on `src_a` only and treat it as signed whatever `signed_mode` is. The most negative input gives the most positive value and counts as a clamp.
- R6: Any clamp in an active lane of an accepted request sets `status` bit 27 with the result; all other status bits read 0. The bit stays set until `status_clr` is high at a clock edge. A clamp in the same cycle as the clear leaves the bit set.
- R7: With `scalar_mode` = 1, only lane 0 is computed. All other result bits are 0, and other lanes never set the flag.
- R8: With `scalar_mode` = 0 and `full_width` = 0, result bits [127:64] are 0 and the lanes there never set the flag.
- R9: Each cycle with `in_valid` high gives `out_valid` high on the next cycle, with the result of that request. `out_valid` is low otherwise.
- R10: While `in_valid` is low, the operands and mode inputs have no effect: `result` holds and the flag does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | 0 add, 1 subtract, 2 absolute value, 3 negate |
| size_sel | input | 2 | Lane width code |
| signed_mode | input | 1 | 1 selects signed add/subtract |
| scalar_mode | input | 1 | 1 computes lane 0 only |
| full_width | input | 1 | 1 for a 128-bit vector, 0 for 64-bit |
| src_a | input | 128 | First operand vector |
| src_b | input | 128 | Second operand vector |
| status_clr | input | 1 | Clears the sticky clamp flag |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 128 | Clamped destination vector |
| status | output | 32 | Status word, clamp flag at bit 27 |

## Verification
The bench pairs every lane width, operation, signedness and mode with operands drawn from zero, one, all ones, the signed maximum, the signed minimum and minimum plus one. These pairs include MAX+MAX, MIN-1, 0-1 unsigned and the negation of MIN. A design that detected overflow by carry alone would clamp signed sums wrongly. A 64-bit lane with a truncated wide adder would wrap instead of pinning. An abs or neg that ignored the MIN case would return MIN itself. Missing lane masking shows up as nonzero upper bits, or as a flag raised by a lane outside the scalar or 64-bit field. A flag that was not sticky, that lost a set coinciding with a clear, or that reacted to idle inputs is caught by the status checks.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_ABS = 2'd2,
    OP_NEG = 2'd3
  } sat_op_e;

  localparam int unsigned NUM_SIZES = 4;

  function automatic int unsigned lane_bits(input int unsigned sz);
    return 8 << sz;
  endfunction
endpackage

// File: rtl/sat_lane.sv
module sat_lane
  import sat_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  sat_op_e      op,
  input  logic         sgn,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam int unsigned  XW   = W + 2;

  function automatic logic [W-1:0] negate(input logic [W-1:0] v);
    return ~v + 1'b1;
  endfunction

  logic         unary_op;
  logic         a_is_min;
  logic [W-1:0] un_res;
  logic [W-1:0] bin_res;
  logic         bin_sat;

  assign unary_op = (op == OP_ABS) || (op == OP_NEG);
  assign a_is_min = (a == SMIN);

  always_comb begin
    if (a_is_min)                         un_res = SMAX;
    else if (op == OP_ABS && !a[W-1])     un_res = a;
    else                                  un_res = negate(a);
  end

  generate
    if (W < 64) begin : g_wide_adder
      logic [XW-1:0] xa, xb, xs;
      assign xa = {{2{sgn & a[W-1]}}, a};
      assign xb = {{2{sgn & b[W-1]}}, b};
      assign xs = (op == OP_SUB) ? (xa - xb) : (xa + xb);
      always_comb begin
        if (sgn) begin
          bin_sat = !((xs[XW-1] == xs[W-1]) && (xs[W] == xs[W-1]));
          bin_res = bin_sat ? (xs[XW-1] ? SMIN : SMAX) : xs[W-1:0];
        end else if (xs[XW-1]) begin
          bin_sat = 1'b1;
          bin_res = '0;
        end else if (xs[W]) begin
          bin_sat = 1'b1;
          bin_res = '1;
        end else begin
          bin_sat = 1'b0;
          bin_res = xs[W-1:0];
        end
      end
    end else begin : g_flag_detect
      logic [W:0]   csum;
      logic [W-1:0] diff;
      logic         s_add_ovf, s_sub_ovf;
      assign csum      = {1'b0, a} + {1'b0, b};
      assign diff      = a - b;
      assign s_add_ovf = ~(a[W-1] ^ b[W-1]) & (a[W-1] ^ csum[W-1]);
      assign s_sub_ovf =  (a[W-1] ^ b[W-1]) & (a[W-1] ^ diff[W-1]);
      always_comb begin
        if (op == OP_SUB) begin
          if (sgn) begin
            bin_sat = s_sub_ovf;
            bin_res = bin_sat ? (a[W-1] ? SMIN : SMAX) : diff;
          end else begin
            bin_sat = (a < b);
            bin_res = bin_sat ? '0 : diff;
          end
        end else begin
          if (sgn) begin
            bin_sat = s_add_ovf;
            bin_res = bin_sat ? (a[W-1] ? SMIN : SMAX) : csum[W-1:0];
          end else begin
            bin_sat = csum[W];
            bin_res = bin_sat ? '1 : csum[W-1:0];
          end
        end
      end
    end
  endgenerate

  assign res = unary_op ? un_res : bin_res;
  assign sat = unary_op ? a_is_min : bin_sat;
endmodule

// File: rtl/sat_vec_alu.sv
module sat_vec_alu
  import sat_pkg::*;
#(
  parameter int unsigned VEC_W    = 128,
  parameter int unsigned STATUS_W = 32,
  parameter int unsigned FLAG_BIT = 27
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          op_sel,
  input  logic [1:0]          size_sel,
  input  logic                signed_mode,
  input  logic                scalar_mode,
  input  logic                full_width,
  input  logic [VEC_W-1:0]    src_a,
  input  logic [VEC_W-1:0]    src_b,
  input  logic                status_clr,
  output logic                out_valid,
  output logic [VEC_W-1:0]    result,
  output logic [STATUS_W-1:0] status
);
  localparam int unsigned MAX_LANES = VEC_W / 8;
  localparam int unsigned HALF      = VEC_W / 2;

  sat_op_e              op;
  logic [VEC_W-1:0]     res_sz [NUM_SIZES];
  logic [MAX_LANES-1:0] sat_sz [NUM_SIZES];
  logic [VEC_W-1:0]     next_res;
  logic                 any_sat;
  logic                 flag_q;

  assign op = sat_op_e'(op_sel);

  for (genvar sz = 0; sz < NUM_SIZES; sz++) begin : g_size
    localparam int unsigned W = lane_bits(sz);
    localparam int unsigned N = VEC_W / W;
    for (genvar i = 0; i < N; i++) begin : g_lane
      logic [W-1:0] l_res;
      logic         l_sat;
      logic         l_en;
      sat_lane #(.W(W)) u_lane (
        .a   (src_a[i*W +: W]),
        .b   (src_b[i*W +: W]),
        .op  (op),
        .sgn (signed_mode),
        .res (l_res),
        .sat (l_sat)
      );
      assign l_en = scalar_mode ? (i == 0) : (full_width || (i < N / 2));
      assign res_sz[sz][i*W +: W] = l_en ? l_res : '0;
      assign sat_sz[sz][i]        = l_en & l_sat;
    end
    if (N < MAX_LANES) begin : g_pad
      assign sat_sz[sz][MAX_LANES-1:N] = '0;
    end
  end

  assign next_res = res_sz[size_sel];
  assign any_sat  = in_valid && (|sat_sz[size_sel]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_q    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
      flag_q <= (flag_q & ~status_clr) | any_sat;
    end
  end

  always_comb begin
    status           = '0;
    status[FLAG_BIT] = flag_q;
  end

  // R9: one-cycle latency of the valid strobe
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R6: sticky flag
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[FLAG_BIT] && !status_clr) |=> status[FLAG_BIT]);
  p_clamp_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_sat |=> status[FLAG_BIT]);
  // R10: idle cycles keep the result
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  // R8: 64-bit vector mode clears the upper half
  p_half_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !scalar_mode && !full_width) |=> (result[VEC_W-1:HALF] == '0));
  // R7: scalar byte mode clears all but lane 0
  p_scalar_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scalar_mode && size_sel == 2'd0) |=> (result[VEC_W-1:8] == '0));
  // R4: unsigned 64-bit subtract floors at zero
  p_usub_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd1 && !signed_mode && size_sel == 2'd3 &&
     src_a[63:0] < src_b[63:0]) |=> (result[63:0] == '0));
  // R5: byte abs of the minimum gives the maximum
  p_abs_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd2 && size_sel == 2'd0 && src_a[7:0] == 8'h80)
    |=> (result[7:0] == 8'h7f));
endmodule

// File: tb/tb_sat_vec_alu.sv
module tb_sat_vec_alu;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   op_sel = '0;
  logic [1:0]   size_sel = '0;
  logic         signed_mode = 1'b0;
  logic         scalar_mode = 1'b0;
  logic         full_width = 1'b0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic         status_clr = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic [31:0]  status;

  sat_vec_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .size_sel(size_sel), .signed_mode(signed_mode), .scalar_mode(scalar_mode),
    .full_width(full_width), .src_a(src_a), .src_b(src_b),
    .status_clr(status_clr), .out_valid(out_valid), .result(result),
    .status(status)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [127:0] res;
    logic         flag;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  logic model_flag = 1'b0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string tag, input string act, input string expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, expv);
    end
  endtask

  function automatic logic [63:0] pv(input int idx, input int w);
    logic [63:0] m, v;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    case (idx)
      0: v = 64'd0;
      1: v = 64'd1;
      2: v = '1;
      3: v = (64'd1 << (w - 1)) - 64'd1;
      4: v = 64'd1 << (w - 1);
      default: v = (64'd1 << (w - 1)) + 64'd1;
    endcase
    return v & m;
  endfunction

  // Reference: exact arithmetic in 68 bits, then clamp to the lane range.
  task automatic ref_lane(input logic [63:0] a, input logic [63:0] b, input int w,
                          input logic [1:0] op, input logic sg,
                          output logic [63:0] r, output logic s);
    logic signed [67:0] x, y, z, mx, mn;
    logic se;
    se = sg || (op >= 2'd2);
    for (int t = 0; t < 68; t++) begin
      x[t] = (t < w) ? a[t] : (se & a[w-1]);
      y[t] = (t < w) ? b[t] : (se & b[w-1]);
    end
    mx = se ? ((68'sd1 <<< (w - 1)) - 68'sd1) : ((68'sd1 <<< w) - 68'sd1);
    mn = se ? -(68'sd1 <<< (w - 1)) : 68'sd0;
    case (op)
      2'd0: z = x + y;
      2'd1: z = x - y;
      2'd2: z = (x < 0) ? -x : x;
      default: z = -x;
    endcase
    s = 1'b0;
    if (z > mx) begin z = mx; s = 1'b1; end
    else if (z < mn) begin z = mn; s = 1'b1; end
    r = z[63:0];
  endtask

  task automatic send(input logic [1:0] op, input logic [1:0] sz, input logic sg,
                      input logic sc, input logic fw, input logic [127:0] a,
                      input logic [127:0] b, input logic clr, input string tag);
    exp_t e;
    int w, nl;
    logic any;
    logic [63:0] la, lb, lr;
    logic ls;
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; size_sel = sz; signed_mode = sg;
    scalar_mode = sc; full_width = fw; src_a = a; src_b = b; status_clr = clr;
    w  = 8 << sz;
    nl = sc ? 1 : ((fw ? 128 : 64) / w);
    e.res = '0; any = 1'b0;
    for (int l = 0; l < nl; l++) begin
      la = '0; lb = '0;
      for (int t = 0; t < w; t++) begin la[t] = a[l*w+t]; lb[t] = b[l*w+t]; end
      ref_lane(la, lb, w, op, sg, lr, ls);
      any |= ls;
      for (int t = 0; t < w; t++) e.res[l*w+t] = lr[t];
    end
    model_flag = (model_flag & ~clr) | any;
    e.flag = model_flag;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0; status_clr = 1'b0;
  endtask

  // Monitor: pops one expected item per valid output.
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected out_valid", "1", "0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(result == e.res, {e.tag, " result"},
              $sformatf("%h", result), $sformatf("%h", e.res));
        check(status[27] == e.flag && status[26:0] == '0 && status[31:28] == '0,
              {e.tag, " R6 status"}, $sformatf("%h", status),
              $sformatf("%h", {4'b0, e.flag, 27'b0}));
      end
    end
  end

  function automatic logic [127:0] fill(input int sz, input int off, input int step);
    logic [127:0] v;
    logic [63:0]  p;
    int w;
    w = 8 << sz;
    v = '0;
    for (int l = 0; l < 128 / w; l++) begin
      p = pv((l * step + off) % 6, w);
      for (int t = 0; t < w; t++) v[l*w+t] = p[t];
    end
    return v;
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [127:0] held;
    string optag, mdtag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && status == '0 && result == '0, "R9 reset state",
          $sformatf("%b/%h/%h", out_valid, status, result), "0/0/0");

    // R2 directed: byte 0x7f + 0x01 signed clamps to 0x7f and sets the flag
    send(2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 128'h01_7f, 128'h01_01, 1'b0, "R2 R7 directed");
    // R6 sticky: non-clamping op keeps the flag
    send(2'd0, 2'd0, 1'b0, 1'b0, 1'b1, '0, '0, 1'b0, "R6 sticky");
    // R6 clear together with a clamp keeps the flag
    send(2'd3, 2'd3, 1'b0, 1'b1, 1'b0, {64'd5, 64'h8000_0000_0000_0000}, '0, 1'b1, "R5 R6 clear+set");
    go_idle();
    @(negedge clk);
    // R6 standalone clear
    status_clr = 1'b1;
    @(negedge clk);
    status_clr = 1'b0;
    model_flag = 1'b0;
    check(status == '0, "R6 clear", $sformatf("%h", status), "0");

    // R10: idle with clamping operands changes nothing
    held = result;
    op_sel = 2'd0; size_sel = 2'd0; signed_mode = 1'b1;
    src_a = {16{8'h7f}}; src_b = {16{8'h7f}}; full_width = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R9 R10 idle valid", $sformatf("%b", out_valid), "0");
    check(status == '0 && result == held, "R10 idle no effect",
          $sformatf("%h/%h", status, result), $sformatf("0/%h", held));

    // Sweep: every op, size, signedness and mode over boundary operands
    for (int op = 0; op < 4; op++)
      for (int sz = 0; sz < 4; sz++)
        for (int sg = 0; sg < 2; sg++)
          for (int md = 0; md < 3; md++)
            for (int k = 0; k < 6; k++)
              for (int j = 0; j < 6; j++) begin
                if (op >= 2)       optag = "R5";
                else if (sg == 0)  optag = "R4";
                else if (op == 0)  optag = "R2";
                else               optag = "R3";
                mdtag = (md == 0) ? "R7" : ((md == 1) ? "R8" : "R9");
                send(2'(op), 2'(sz), 1'(sg), md == 0, md == 2,
                     fill(sz, k, 1), fill(sz, j, 5), (k == 0 && j == 0),
                     $sformatf("R1 %s %s op=%0d sz=%0d sg=%0d md=%0d", optag, mdtag, op, sz, sg, md));
              end
    go_idle();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all results delivered",
          $sformatf("%0d", exp_q.size()), "0");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule